// File: doc/BRIEF.md
# MDIO Management Interface Master

This block is the master side of the two-wire MII management bus. It generates the management clock (MDC) and drives or releases the bidirectional data line so that a host can read and write 16-bit registers in an external PHY. The pad is modelled as three separate signals: a data output, an output enable and a data input. The output enable is high when the master drives the line.

A command is a single-cycle start pulse with a read/write select, a 5-bit PHY address, a 5-bit register address and 16 bits of write data. The block then runs one whole frame. The frame has a preamble of ones, the start and opcode bits, both addresses, the turnaround and the data field. The block ends each frame with a one-cycle done pulse and an error flag. On reads, the block checks that the PHY pulls the second turnaround bit low. When the PHY does not, the block clocks out a run of idle periods and reports an error. In that case it returns no data.

The speed of the management clock comes from a half-period divider. The divider is loaded when a command is accepted.

Top module: `mdio_master`

## Requirements
- R1: After reset, and whenever `busy` is low, `mdc` is low and `mdio_oe` is low. `done` and `err` reset to 0.
- R2: Every frame opens with 32 management clock periods. In each of them the master drives the data line to 1 (`mdio_oe`=1, `mdio_o`=1).
- R3: After the preamble the master drives the start bits 0 then 1. It then drives the opcode: 1,0 for a read (`cmd_read`=1) or 0,1 for a write.
- R4: Next the master drives the 5-bit PHY address, then the 5-bit register address, each most significant bit first.
- R5: `mdio_o` and `mdio_oe` change only while `mdc` is low. They hold steady through every high phase, so the value at each rising edge is stable.
- R6: On a write, the master drives the turnaround as 1 then 0 and then the 16 data bits, MSB first. It then releases the line for one more clock period, so the frame has 65 rising edges.
- R7: On a read, the line is released from the first turnaround bit onward. The PHY's value is sampled near the end of the high phase of the second turnaround bit and of each of the 16 data bits. The data is assembled MSB first, two released clock periods follow, and `rd_data` shows the result at `done`. The frame has 66 rising edges.
- R8: If the second turnaround sample of a read is 1, the master clocks 32 further periods with the line released and then ends the frame with `err`=1. That frame has 80 rising edges, and `rd_data` keeps its previous value.
- R9: Each high phase and each low phase of `mdc` lasts `half_div` clock cycles. A frame of N bit periods keeps `busy` high for 2·N·`half_div` cycles. A `half_div` of 0 acts as 1.
- R10: `busy` rises in the cycle after an accepted start and stays high until `done`. `done` is high for exactly one cycle, with `busy` already low. A start pulse while `busy` is high is ignored and does not change the frame in progress.
- R11: A frame that completes normally clears `err` to 0. `err` holds its value until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start | input | 1 | Single-cycle request to run a frame |
| cmd_read | input | 1 | 1 selects a read, 0 selects a write |
| cmd_phy | input | 5 | PHY address |
| cmd_reg | input | 5 | Register address within the PHY |
| cmd_wdata | input | 16 | Data for a write |
| half_div | input | 8 | Management clock half-period in system clock cycles |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data value towards the pad |
| mdio_oe | output | 1 | 1 while the master drives the data line |
| mdio_i | input | 1 | Data value read from the pad |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | The last frame failed the turnaround check |
| rd_data | output | 16 | Data returned by the last successful read |

## Verification
The assertions check on every cycle that the data line and its enable hold steady while the management clock is high. They also check that the bus is quiet whenever the block is not busy, that the clock holds its level inside a half period, and that done is a lone pulse with busy already low. Finally, they check that the error flag and the returned data change only at completion. The order of the bits in a frame, the frame lengths, the exact half-period widths, the result of the turnaround check and the rejection of a second start are properties of whole frames. Only the bench scenarios can show them, by logging every rising edge of the management clock against a model of the PHY.

// File: rtl/mdio_master_pkg.sv
`timescale 1ns/1ps
package mdio_master_pkg;
   typedef enum logic [2:0] {
      PH_IDLE, PH_PRE, PH_HDR, PH_TA, PH_DATA, PH_TAIL, PH_ERR
   } phase_e;

   localparam logic [1:0] SOF_PAT = 2'b01;
   localparam logic [1:0] OP_RD   = 2'b10;
   localparam logic [1:0] OP_WR   = 2'b01;
   localparam logic [1:0] TA_WR   = 2'b10;
endpackage

// File: rtl/mdio_halfclk.sv
`timescale 1ns/1ps
module mdio_halfclk #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             run,
   input  logic [DIV_W-1:0] div_in,
   output logic             mdc,
   output logic             bit_end
);
   localparam logic [DIV_W-1:0] DIV_ONE = {{(DIV_W-1){1'b0}}, 1'b1};

   if (DIV_W < 1) begin : g_bad_div_w
      $error("DIV_W must be at least 1");
   end

   logic [DIV_W-1:0] div_q, hcnt, div_eff;
   logic             hi_q;

   assign div_eff = (div_in == '0) ? DIV_ONE : div_in;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         div_q <= DIV_ONE;
         hcnt  <= '0;
         hi_q  <= 1'b0;
      end else if (load) begin
         div_q <= div_eff;
         hcnt  <= div_eff - DIV_ONE;
         hi_q  <= 1'b0;
      end else if (!run) begin
         hcnt  <= div_q - DIV_ONE;
         hi_q  <= 1'b0;
      end else if (hcnt == '0) begin
         hi_q  <= ~hi_q;
         hcnt  <= div_q - DIV_ONE;
      end else begin
         hcnt  <= hcnt - DIV_ONE;
      end
   end

   assign mdc     = hi_q;
   assign bit_end = run && hi_q && (hcnt == '0);

   a_r9_level_held: assert property (@(posedge clk) disable iff (!rst_n)
      (run && hcnt != '0) |=> (hi_q == $past(hi_q)));
endmodule

// File: rtl/mdio_seq.sv
`timescale 1ns/1ps
module mdio_seq
   import mdio_master_pkg::*;
#(
   parameter int PHY_W    = 5,
   parameter int REG_W    = 5,
   parameter int DATA_W   = 16,
   parameter int PRE_BITS = 32,
   parameter int RD_TAIL  = 2,
   parameter int WR_TAIL  = 1,
   parameter int ERR_CLKS = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              rnw,
   input  logic [PHY_W-1:0]  phy_addr,
   input  logic [REG_W-1:0]  reg_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              bit_end,
   input  logic              mdio_i,
   output logic              accept,
   output logic              running,
   output logic              mdio_o,
   output logic              mdio_oe,
   output logic [DATA_W-1:0] rd_data,
   output logic              done,
   output logic              err
);
   localparam int HDR_BITS = 4 + PHY_W + REG_W;
   localparam int FRAME_W  = HDR_BITS + 2 + DATA_W;
   localparam int CNT_W    = $clog2(PRE_BITS + ERR_CLKS + FRAME_W + RD_TAIL + WR_TAIL + 1);

   if (DATA_W < 2) begin : g_bad_data_w
      $error("DATA_W must be at least 2");
   end
   if (PRE_BITS < 1 || ERR_CLKS < 1 || RD_TAIL < 1 || WR_TAIL < 1) begin : g_bad_len
      $error("preamble, error and tail lengths must be at least 1");
   end
   if (PHY_W < 1 || REG_W < 1) begin : g_bad_addr_w
      $error("address widths must be at least 1");
   end

   phase_e             state;
   logic [CNT_W-1:0]   cnt;
   logic [FRAME_W-1:0] tx_sh;
   logic [DATA_W-1:0]  rx_sh;
   logic               rd_q;
   logic               last;

   assign accept  = start && (state == PH_IDLE);
   assign running = (state != PH_IDLE);
   assign last    = (cnt == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= PH_IDLE;
         cnt     <= '0;
         tx_sh   <= '0;
         rx_sh   <= '0;
         rd_q    <= 1'b0;
         rd_data <= '0;
         done    <= 1'b0;
         err     <= 1'b0;
      end else begin
         done <= 1'b0;
         if (accept) begin
            state <= PH_PRE;
            cnt   <= CNT_W'(PRE_BITS - 1);
            rd_q  <= rnw;
            tx_sh <= {SOF_PAT, (rnw ? OP_RD : OP_WR), phy_addr, reg_addr, TA_WR, wr_data};
         end else if (bit_end) begin
            unique case (state)
               PH_PRE: begin
                  if (last) begin
                     state <= PH_HDR;
                     cnt   <= CNT_W'(HDR_BITS - 1);
                  end else cnt <= cnt - 1'b1;
               end
               PH_HDR: begin
                  tx_sh <= tx_sh << 1;
                  if (last) begin
                     state <= PH_TA;
                     cnt   <= CNT_W'(1);
                  end else cnt <= cnt - 1'b1;
               end
               PH_TA: begin
                  tx_sh <= tx_sh << 1;
                  if (last) begin
                     if (rd_q && mdio_i) begin
                        state <= PH_ERR;
                        cnt   <= CNT_W'(ERR_CLKS - 1);
                     end else begin
                        state <= PH_DATA;
                        cnt   <= CNT_W'(DATA_W - 1);
                     end
                  end else cnt <= cnt - 1'b1;
               end
               PH_DATA: begin
                  tx_sh <= tx_sh << 1;
                  rx_sh <= {rx_sh[DATA_W-2:0], mdio_i};
                  if (last) begin
                     state <= PH_TAIL;
                     cnt   <= rd_q ? CNT_W'(RD_TAIL - 1) : CNT_W'(WR_TAIL - 1);
                  end else cnt <= cnt - 1'b1;
               end
               PH_TAIL: begin
                  if (last) begin
                     state <= PH_IDLE;
                     done  <= 1'b1;
                     err   <= 1'b0;
                     if (rd_q) rd_data <= rx_sh;
                  end else cnt <= cnt - 1'b1;
               end
               PH_ERR: begin
                  if (last) begin
                     state <= PH_IDLE;
                     done  <= 1'b1;
                     err   <= 1'b1;
                  end else cnt <= cnt - 1'b1;
               end
               default: state <= PH_IDLE;
            endcase
         end
      end
   end

   always_comb begin
      mdio_oe = 1'b0;
      mdio_o  = 1'b1;
      unique case (state)
         PH_PRE: mdio_oe = 1'b1;
         PH_HDR: begin
            mdio_oe = 1'b1;
            mdio_o  = tx_sh[FRAME_W-1];
         end
         PH_TA, PH_DATA: begin
            mdio_oe = !rd_q;
            mdio_o  = tx_sh[FRAME_W-1];
         end
         default: ;
      endcase
   end

   a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !running);
   a_r8_err_at_done: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err) |-> done);
   a_r7_data_at_done: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rd_data) |-> done);
endmodule

// File: rtl/mdio_master.sv
`timescale 1ns/1ps
module mdio_master #(
   parameter int DIV_W    = 8,
   parameter int PHY_W    = 5,
   parameter int REG_W    = 5,
   parameter int DATA_W   = 16,
   parameter int PRE_BITS = 32,
   parameter int RD_TAIL  = 2,
   parameter int WR_TAIL  = 1,
   parameter int ERR_CLKS = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_start,
   input  logic              cmd_read,
   input  logic [PHY_W-1:0]  cmd_phy,
   input  logic [REG_W-1:0]  cmd_reg,
   input  logic [DATA_W-1:0] cmd_wdata,
   input  logic [DIV_W-1:0]  half_div,
   output logic              mdc,
   output logic              mdio_o,
   output logic              mdio_oe,
   input  logic              mdio_i,
   output logic              busy,
   output logic              done,
   output logic              err,
   output logic [DATA_W-1:0] rd_data
);
   logic accept, bit_end;

   mdio_halfclk #(.DIV_W(DIV_W)) u_clk (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (accept),
      .run     (busy),
      .div_in  (half_div),
      .mdc     (mdc),
      .bit_end (bit_end)
   );

   mdio_seq #(
      .PHY_W(PHY_W), .REG_W(REG_W), .DATA_W(DATA_W), .PRE_BITS(PRE_BITS),
      .RD_TAIL(RD_TAIL), .WR_TAIL(WR_TAIL), .ERR_CLKS(ERR_CLKS)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (cmd_start),
      .rnw      (cmd_read),
      .phy_addr (cmd_phy),
      .reg_addr (cmd_reg),
      .wr_data  (cmd_wdata),
      .bit_end  (bit_end),
      .mdio_i   (mdio_i),
      .accept   (accept),
      .running  (busy),
      .mdio_o   (mdio_o),
      .mdio_oe  (mdio_oe),
      .rd_data  (rd_data),
      .done     (done),
      .err      (err)
   );

   a_r5_hold_while_high: assert property (@(posedge clk) disable iff (!rst_n)
      mdc |-> ($stable(mdio_o) && $stable(mdio_oe)));
   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mdc && !mdio_oe));
endmodule

// File: tb/mdio_master_bench.sv
`timescale 1ns/1ps
module mdio_master_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_start = 1'b0, cmd_read = 1'b0;
   logic [4:0]  cmd_phy = '0, cmd_reg = '0;
   logic [15:0] cmd_wdata = '0;
   logic [7:0]  half_div = 8'd1;
   logic        mdc, mdio_o, mdio_oe, busy, done, err;
   logic        mdio_i = 1'b1;
   logic [15:0] rd_data;

   always #10 clk = ~clk;

   mdio_master u_mdio_master (
      .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_read(cmd_read),
      .cmd_phy(cmd_phy), .cmd_reg(cmd_reg), .cmd_wdata(cmd_wdata),
      .half_div(half_div), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
      .mdio_i(mdio_i), .busy(busy), .done(done), .err(err), .rd_data(rd_data)
   );

   int n_chk = 0, n_err = 0;

   // PHY model controls (written only by the test flow)
   logic        phy_en = 1'b0, phy_ta = 1'b0;
   logic [15:0] phy_dat = '0;

   // monitor state (written only by the monitor)
   logic cap_o[0:127];
   logic cap_oe[0:127];
   int   nrise = 0, busy_cyc = 0, done_cnt = 0;
   int   hi_run = 0, lo_run = 0, hi_w = 0, lo_w = 0;
   logic mdc_q = 1'b0, busy_q = 1'b0;

   always @(negedge clk) begin
      if (busy && !busy_q) begin
         nrise = 0; busy_cyc = 0; done_cnt = 0;
         hi_run = 0; lo_run = 0;
      end
      if (busy) busy_cyc++;
      if (done) done_cnt++;
      if (mdc && !mdc_q) begin
         if (nrise < 128) begin
            cap_o[nrise]  = mdio_o;
            cap_oe[nrise] = mdio_oe;
         end
         if (phy_en && nrise == 47) mdio_i = phy_ta;
         else if (phy_en && nrise >= 48 && nrise < 64) mdio_i = phy_dat[63-nrise];
         else mdio_i = 1'b1;
         nrise++;
         lo_w = lo_run; lo_run = 0; hi_run = 0;
      end
      if (!mdc && mdc_q) begin
         hi_w = hi_run; hi_run = 0;
      end
      if (mdc) hi_run++;
      else if (busy) lo_run++;
      mdc_q  = mdc;
      busy_q = busy;
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic exp_bit(input bit rnw, input logic [4:0] pa,
                                    input logic [4:0] ra, input logic [15:0] wd, input int i);
      if (i < 32) return 1'b1;
      if (i == 32) return 1'b0;
      if (i == 33) return 1'b1;
      if (i == 34) return rnw;
      if (i == 35) return !rnw;
      if (i <= 40) return pa[40-i];
      if (i <= 45) return ra[45-i];
      if (i == 46) return 1'b1;
      if (i == 47) return 1'b0;
      if (i <= 63) return wd[63-i];
      return 1'b1;
   endfunction

   // rnw / fail_ta select the frame shape; tail_req names the requirement for bits 46+
   task automatic verify_frame(input bit rnw, input bit fail_ta, input logic [4:0] pa,
                               input logic [4:0] ra, input logic [15:0] wd,
                               input int exp_rises, input string tail_req);
      int bad_pre = 0, bad_sop = 0, bad_adr = 0, bad_tail = 0;
      chk(nrise == exp_rises, tail_req, "rising edges per frame", nrise, exp_rises);
      for (int i = 0; i < exp_rises && i < nrise && i < 128; i++) begin
         logic eo, eoe;
         eo  = exp_bit(rnw, pa, ra, wd, i);
         eoe = (i < 46) || (!rnw && !fail_ta && i < 64);
         if (cap_oe[i] != eoe || (eoe && cap_o[i] != eo)) begin
            if (i < 32) bad_pre++;
            else if (i < 36) bad_sop++;
            else if (i < 46) bad_adr++;
            else bad_tail++;
         end
      end
      chk(bad_pre == 0, "R2", "preamble bits wrong", bad_pre, 0);
      chk(bad_sop == 0, "R3", "start/opcode bits wrong", bad_sop, 0);
      chk(bad_adr == 0, "R4", "address bits wrong", bad_adr, 0);
      chk(bad_tail == 0, tail_req, "turnaround/data/tail bits wrong", bad_tail, 0);
   endtask

   task automatic run_txn(input bit rnw, input logic [4:0] pa, input logic [4:0] ra,
                          input logic [15:0] wd, input logic [7:0] div, input bit intrude);
      bit seen = 0;
      @(negedge clk);
      cmd_read = rnw; cmd_phy = pa; cmd_reg = ra; cmd_wdata = wd; half_div = div;
      cmd_start = 1'b1;
      @(negedge clk);
      cmd_start = 1'b0;
      chk(busy == 1'b1, "R10", "busy in cycle after start", busy, 1);
      if (intrude) begin
         repeat (40) @(negedge clk);
         cmd_read = !rnw; cmd_phy = ~pa; cmd_reg = ~ra; cmd_wdata = ~wd; half_div = 8'd5;
         cmd_start = 1'b1;
         @(negedge clk);
         cmd_start = 1'b0;
      end
      for (int i = 0; i < 5000; i++) begin
         @(negedge clk);
         if (done) begin seen = 1; break; end
      end
      chk(seen, "R10", "done pulse seen", seen, 1);
      chk(busy == 1'b0, "R10", "busy low with done", busy, 0);
   endtask

   task automatic post_done(input int exp_busy);
      chk(busy_cyc == exp_busy, "R9", "busy cycles per frame", busy_cyc, exp_busy);
      @(negedge clk);
      chk(done == 1'b0, "R10", "done lasts one cycle", done, 0);
      repeat (4) @(negedge clk);
      chk(done_cnt == 1, "R10", "done pulses per frame", done_cnt, 1);
      chk(!mdc && !mdio_oe && !busy, "R1", "bus quiet after frame", {mdc, mdio_oe, busy}, 0);
   endtask

   task automatic t_reset();
      chk(busy == 1'b0, "R1", "busy after reset", busy, 0);
      chk(mdc == 1'b0, "R1", "mdc after reset", mdc, 0);
      chk(mdio_oe == 1'b0, "R1", "oe after reset", mdio_oe, 0);
      chk(done == 1'b0 && err == 1'b0, "R1", "done/err after reset", {done, err}, 0);
   endtask

   task automatic t_write();
      phy_en = 1'b0;
      run_txn(1'b0, 5'h11, 5'h0A, 16'hA5C3, 8'd1, 1'b0);
      chk(err == 1'b0, "R6", "err after write", err, 0);
      verify_frame(1'b0, 1'b0, 5'h11, 5'h0A, 16'hA5C3, 65, "R6");
      post_done(130);
   endtask

   task automatic t_read();
      phy_en = 1'b1; phy_ta = 1'b0; phy_dat = 16'h3C5A;
      run_txn(1'b1, 5'h03, 5'h1F, 16'h0000, 8'd2, 1'b0);
      chk(rd_data == 16'h3C5A, "R7", "read data", rd_data, 16'h3C5A);
      chk(err == 1'b0, "R7", "err after read", err, 0);
      verify_frame(1'b1, 1'b0, 5'h03, 5'h1F, 16'h0000, 66, "R7");
      chk(hi_w == 2 && lo_w == 2, "R9", "half widths for div 2", hi_w * 16 + lo_w, 8'h22);
      post_done(264);
      phy_en = 1'b0;
   endtask

   task automatic t_read_err();
      phy_en = 1'b1; phy_ta = 1'b1; phy_dat = 16'hFFFF;
      run_txn(1'b1, 5'h1E, 5'h01, 16'h0000, 8'd1, 1'b0);
      chk(err == 1'b1, "R8", "err on high turnaround", err, 1);
      chk(rd_data == 16'h3C5A, "R8", "read data kept on error", rd_data, 16'h3C5A);
      verify_frame(1'b1, 1'b1, 5'h1E, 5'h01, 16'h0000, 80, "R8");
      post_done(160);
      phy_en = 1'b0;
   endtask

   task automatic t_err_clear();
      phy_en = 1'b1; phy_ta = 1'b0; phy_dat = 16'h8001;
      run_txn(1'b1, 5'h00, 5'h10, 16'h0000, 8'd3, 1'b0);
      chk(err == 1'b0, "R11", "err cleared by good read", err, 0);
      chk(rd_data == 16'h8001, "R7", "read data edge bits", rd_data, 16'h8001);
      chk(hi_w == 3 && lo_w == 3, "R9", "half widths for div 3", hi_w * 16 + lo_w, 8'h33);
      post_done(396);
      phy_en = 1'b0;
   endtask

   task automatic t_div_zero();
      run_txn(1'b0, 5'h1F, 5'h00, 16'h0001, 8'd0, 1'b0);
      chk(hi_w == 1 && lo_w == 1, "R9", "div 0 acts as 1", hi_w * 16 + lo_w, 8'h11);
      verify_frame(1'b0, 1'b0, 5'h1F, 5'h00, 16'h0001, 65, "R6");
      post_done(130);
   endtask

   task automatic t_busy_ignore();
      run_txn(1'b0, 5'h15, 5'h0B, 16'h7E81, 8'd1, 1'b1);
      verify_frame(1'b0, 1'b0, 5'h15, 5'h0B, 16'h7E81, 65, "R10");
      chk(err == 1'b0, "R10", "err after ignored start", err, 0);
      post_done(130);
   endtask

   initial begin
      bit timed_out = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      fork
         begin
            t_reset();
            t_write();
            t_read();
            t_read_err();
            t_err_clear();
            t_div_zero();
            t_busy_ignore();
         end
         begin
            #4000000;
            timed_out = 1;
         end
      join_any
      disable fork;
      if (timed_out) begin
         n_chk++; n_err++;
         $display("FAIL watchdog: actual=hung expected=finished");
      end
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule